// File: doc/BRIEF.md
# Max/min load selector tree

This block picks, once per balancer clock, the most loaded and the least loaded node of a grid of load-balancing nodes and marks the route between them. The nodes form a tree over the grid. Each row is a horizontal chain that runs toward the root column. The nodes of the root column form one vertical chain that ends at the root node. Every node compares its own job count with the winning counts its children report. It passes the largest and the smallest up to its parent and remembers which input supplied each.

The root compares the overall largest and smallest counts. When they differ by two or more, it sends a source request and a destination request back down the tree. Each node steers each request toward the child it remembered and records that direction as its switch setting. The node that keeps a request for itself is the chosen source or destination. The whole up-and-down pass is combinational. Its results are captured in one register stage.

A node in transparent mode offers no count of its own, so it is never chosen. It still relays its children's results in both directions.

Top module: `lsel_tree`

## Requirements
- R1: `max_cnt` and `min_cnt` hold the largest and smallest job count among all nodes that are not transparent, as sampled at the previous clock edge.
- R2: `xfer_go` is 1 exactly when that largest count exceeds that smallest count by two or more. A gap of 0 or 1 gives 0.
- R3: While `xfer_go` is 1, exactly one bit of `src_pick` is set and exactly one bit of `dst_pick` is set, on different nodes. The source node's count equals `max_cnt` and the destination node's count equals `min_cnt`. While `xfer_go` is 0, both vectors are zero.
- R4: Equal counts are resolved at each node in a fixed order: the node's own count first, then its west, east, north and south children.
- R5: A transparent node is never picked as source or destination. Nodes beneath it in the tree remain eligible.
- R6: When every node is transparent, `max_cnt` is 0, `min_cnt` is all ones and `xfer_go` is 0.
- R7: Each node has a 3-bit source switch code and a 3-bit destination switch code. The codes are 0 = local, 1 = west, 2 = east, 3 = north, 4 = south and 7 = idle. A node on the tree path from the root to the source points its source code at the next node on that path, and the source node itself shows 0. Every other node shows 7. The destination codes follow the same rule. With no transfer, all codes are 7.
- R8: Every output is registered. A synchronous active-high reset sets `xfer_go` to 0, both pick vectors to 0, both counts to 0 and every switch code to 7.
- R9: Counts are compared over their full range without wrap: a largest count of all ones against a smallest count of 0 gives a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Balancer clock |
| rst | input | 1 | Synchronous active-high reset |
| job_cnt | input | ROWS*COLS*CW | Job count of each node; node r*COLS+c at bits [k*CW +: CW] |
| transp | input | ROWS*COLS | Transparent-mode flag per node |
| xfer_go | output | 1 | A transfer is ordered this cycle |
| src_pick | output | ROWS*COLS | One-hot source node |
| dst_pick | output | ROWS*COLS | One-hot destination node |
| sw_src | output | ROWS*COLS*3 | Per-node source switch code, node k at [3k +: 3] |
| sw_dst | output | ROWS*COLS*3 | Per-node destination switch code, node k at [3k +: 3] |
| max_cnt | output | CW | Largest count among non-transparent nodes |
| min_cnt | output | CW | Smallest count among non-transparent nodes |

## Verification
The hardest cases to reach from the ports are equal counts that meet inside the tree and transparent nodes that must still relay a winner from below. The pick alone does not show which input a node preferred. The switch codes along the whole path do, so every vector checks all of them against a path model of the grid. Directed cases place equal maxima on the root and its east child, on its west and east subtrees, and on its north and south subtrees. Other cases mask the root, mask a relaying row node above the winning leaf, and mask every node at once.

// File: rtl/lsel_pkg.sv
package lsel_pkg;

    localparam int NUM_CH = 4;

    typedef enum logic [2:0] {
        PORT_LOCAL = 3'd0,
        PORT_W     = 3'd1,
        PORT_E     = 3'd2,
        PORT_N     = 3'd3,
        PORT_S     = 3'd4,
        PORT_IDLE  = 3'd7
    } port_e;

    // child slot s (0..3 = W,E,N,S) maps to the port code s+1
    function automatic port_e slot_port(input int s);
        return port_e'(3'(s + 1));
    endfunction

    // a transfer is worth doing when hi - lo >= 2
    function automatic logic wide_gap(input int unsigned hi, input int unsigned lo);
        return hi >= lo + 32'd2;
    endfunction

endpackage

// File: rtl/lsel_pick.sv
module lsel_pick
    import lsel_pkg::*;
#(
    parameter int CW       = 4,
    parameter bit FIND_MAX = 1'b1
) (
    input  logic [CW-1:0]             own_cnt,
    input  logic                      own_off,
    input  logic [NUM_CH-1:0][CW-1:0] ch_cnt,
    output logic [CW-1:0]             best,
    output port_e                     best_port
);

    // a masked input carries a value that can never beat a real one
    localparam logic [CW-1:0] SENTINEL = FIND_MAX ? {CW{1'b0}} : {CW{1'b1}};

    logic [CW-1:0] run_val;
    port_e         run_port;

    generate
        if (FIND_MAX) begin : g_max
            always_comb begin
                run_val  = own_off ? SENTINEL : own_cnt;
                run_port = PORT_LOCAL;
                for (int s = 0; s < NUM_CH; s++) begin
                    if (ch_cnt[s] > run_val) begin
                        run_val  = ch_cnt[s];
                        run_port = slot_port(s);
                    end
                end
            end
        end else begin : g_min
            always_comb begin
                run_val  = own_off ? SENTINEL : own_cnt;
                run_port = PORT_LOCAL;
                for (int s = 0; s < NUM_CH; s++) begin
                    if (ch_cnt[s] < run_val) begin
                        run_val  = ch_cnt[s];
                        run_port = slot_port(s);
                    end
                end
            end
        end
    endgenerate

    assign best      = run_val;
    assign best_port = run_port;

endmodule

// File: rtl/lsel_node.sv
module lsel_node
    import lsel_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic [CW-1:0]             own_cnt,
    input  logic                      own_off,
    input  logic [NUM_CH-1:0][CW-1:0] ch_max,
    input  logic [NUM_CH-1:0][CW-1:0] ch_min,
    output logic [CW-1:0]             up_max,
    output logic [CW-1:0]             up_min,
    input  logic                      req_src,
    input  logic                      req_dst,
    output logic [NUM_CH-1:0]         fwd_src,
    output logic [NUM_CH-1:0]         fwd_dst,
    output logic                      hit_src,
    output logic                      hit_dst,
    output port_e                     sw_src,
    output port_e                     sw_dst
);

    port_e win_max;
    port_e win_min;

    lsel_pick #(.CW(CW), .FIND_MAX(1'b1)) u_pick_max (
        .own_cnt   (own_cnt),
        .own_off   (own_off),
        .ch_cnt    (ch_max),
        .best      (up_max),
        .best_port (win_max)
    );

    lsel_pick #(.CW(CW), .FIND_MAX(1'b0)) u_pick_min (
        .own_cnt   (own_cnt),
        .own_off   (own_off),
        .ch_cnt    (ch_min),
        .best      (up_min),
        .best_port (win_min)
    );

    // downward steering: each request follows the remembered winner
    always_comb begin
        for (int s = 0; s < NUM_CH; s++) begin
            fwd_src[s] = req_src && (win_max == slot_port(s));
            fwd_dst[s] = req_dst && (win_min == slot_port(s));
        end
        hit_src = req_src && (win_max == PORT_LOCAL);
        hit_dst = req_dst && (win_min == PORT_LOCAL);
        sw_src  = req_src ? win_max : PORT_IDLE;
        sw_dst  = req_dst ? win_min : PORT_IDLE;
    end

endmodule

// File: rtl/lsel_root.sv
module lsel_root
    import lsel_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic [CW-1:0] top_max,
    input  logic [CW-1:0] top_min,
    output logic          go
);

    assign go = wide_gap(32'(top_max), 32'(top_min));

endmodule

// File: rtl/lsel_tree.sv
module lsel_tree
    import lsel_pkg::*;
#(
    parameter int CW       = 4,
    parameter int ROWS     = 3,
    parameter int COLS     = 4,
    parameter int ROOT_ROW = 1,
    parameter int ROOT_COL = 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [ROWS*COLS*CW-1:0]   job_cnt,
    input  logic [ROWS*COLS-1:0]      transp,
    output logic                      xfer_go,
    output logic [ROWS*COLS-1:0]      src_pick,
    output logic [ROWS*COLS-1:0]      dst_pick,
    output logic [ROWS*COLS*3-1:0]    sw_src,
    output logic [ROWS*COLS*3-1:0]    sw_dst,
    output logic [CW-1:0]             max_cnt,
    output logic [CW-1:0]             min_cnt
);

    localparam int N     = ROWS * COLS;
    localparam int ROOT  = ROOT_ROW * COLS + ROOT_COL;

    // combinational tree signals
    logic [CW-1:0]     up_max  [N];
    logic [CW-1:0]     up_min  [N];
    logic [NUM_CH-1:0] fwd_src [N];
    logic [NUM_CH-1:0] fwd_dst [N];
    logic [N-1:0]      req_src;
    logic [N-1:0]      req_dst;
    logic [N-1:0]      hit_src;
    logic [N-1:0]      hit_dst;
    logic [N-1:0]      stray;
    port_e             sw_s    [N];
    port_e             sw_d    [N];
    logic              root_go;

    // registered outputs
    logic              go_q;
    logic [N-1:0]      src_q;
    logic [N-1:0]      dst_q;
    logic [CW-1:0]     max_q;
    logic [CW-1:0]     min_q;
    port_e             sw_s_q  [N];
    port_e             sw_d_q  [N];

    lsel_root #(.CW(CW)) u_root (
        .top_max (up_max[ROOT]),
        .top_min (up_min[ROOT]),
        .go      (root_go)
    );

    generate
        for (genvar r = 0; r < ROWS; r++) begin : g_row
            for (genvar c = 0; c < COLS; c++) begin : g_col
                localparam int K     = r * COLS + c;
                localparam bit HAS_W = (c > 0) && (c <= ROOT_COL);
                localparam bit HAS_E = (c >= ROOT_COL) && (c < COLS - 1);
                localparam bit HAS_N = (c == ROOT_COL) && (r > 0) && (r <= ROOT_ROW);
                localparam bit HAS_S = (c == ROOT_COL) && (r >= ROOT_ROW) && (r < ROWS - 1);
                localparam logic [NUM_CH-1:0] CH_MASK = {HAS_S, HAS_N, HAS_E, HAS_W};

                logic [NUM_CH-1:0][CW-1:0] cx;
                logic [NUM_CH-1:0][CW-1:0] cn;

                // child slot 0: west
                if (HAS_W) begin : g_w
                    assign cx[0] = up_max[K-1];
                    assign cn[0] = up_min[K-1];
                end else begin : g_nw
                    assign cx[0] = '0;
                    assign cn[0] = '1;
                end
                // child slot 1: east
                if (HAS_E) begin : g_e
                    assign cx[1] = up_max[K+1];
                    assign cn[1] = up_min[K+1];
                end else begin : g_ne
                    assign cx[1] = '0;
                    assign cn[1] = '1;
                end
                // child slot 2: north
                if (HAS_N) begin : g_n
                    assign cx[2] = up_max[K-COLS];
                    assign cn[2] = up_min[K-COLS];
                end else begin : g_nn
                    assign cx[2] = '0;
                    assign cn[2] = '1;
                end
                // child slot 3: south
                if (HAS_S) begin : g_s
                    assign cx[3] = up_max[K+COLS];
                    assign cn[3] = up_min[K+COLS];
                end else begin : g_ns
                    assign cx[3] = '0;
                    assign cn[3] = '1;
                end

                // request arriving from the parent
                if (K == ROOT) begin : g_top
                    assign req_src[K] = root_go;
                    assign req_dst[K] = root_go;
                end else if (c < ROOT_COL) begin : g_pe
                    assign req_src[K] = fwd_src[K+1][0];
                    assign req_dst[K] = fwd_dst[K+1][0];
                end else if (c > ROOT_COL) begin : g_pw
                    assign req_src[K] = fwd_src[K-1][1];
                    assign req_dst[K] = fwd_dst[K-1][1];
                end else if (r < ROOT_ROW) begin : g_ps
                    assign req_src[K] = fwd_src[K+COLS][2];
                    assign req_dst[K] = fwd_dst[K+COLS][2];
                end else begin : g_pn
                    assign req_src[K] = fwd_src[K-COLS][3];
                    assign req_dst[K] = fwd_dst[K-COLS][3];
                end

                lsel_node #(.CW(CW)) u_node (
                    .own_cnt (job_cnt[K*CW +: CW]),
                    .own_off (transp[K]),
                    .ch_max  (cx),
                    .ch_min  (cn),
                    .up_max  (up_max[K]),
                    .up_min  (up_min[K]),
                    .req_src (req_src[K]),
                    .req_dst (req_dst[K]),
                    .fwd_src (fwd_src[K]),
                    .fwd_dst (fwd_dst[K]),
                    .hit_src (hit_src[K]),
                    .hit_dst (hit_dst[K]),
                    .sw_src  (sw_s[K]),
                    .sw_dst  (sw_d[K])
                );

                // a request steered toward a child slot that does not exist
                assign stray[K] = |((fwd_src[K] | fwd_dst[K]) & ~CH_MASK);

                assign sw_src[3*K +: 3] = sw_s_q[K];
                assign sw_dst[3*K +: 3] = sw_d_q[K];

                AST_SRC_COUNT: assert property (@(posedge clk) disable iff (rst)
                    src_q[K] |-> (max_q == $past(job_cnt[K*CW +: CW])))
                    else $error("source count is not the maximum");      // R3
                AST_DST_COUNT: assert property (@(posedge clk) disable iff (rst)
                    dst_q[K] |-> (min_q == $past(job_cnt[K*CW +: CW])))
                    else $error("destination count is not the minimum"); // R3
                AST_SRC_AT_HOME: assert property (@(posedge clk) disable iff (rst)
                    src_q[K] |-> (sw_s_q[K] == PORT_LOCAL))
                    else $error("source node switch not local");          // R7
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            go_q  <= 1'b0;
            src_q <= '0;
            dst_q <= '0;
            max_q <= '0;
            min_q <= '0;
            for (int k = 0; k < N; k++) begin
                sw_s_q[k] <= PORT_IDLE;
                sw_d_q[k] <= PORT_IDLE;
            end
        end else begin
            go_q  <= root_go;
            src_q <= hit_src;
            dst_q <= hit_dst;
            max_q <= up_max[ROOT];
            min_q <= up_min[ROOT];
            for (int k = 0; k < N; k++) begin
                sw_s_q[k] <= sw_s[k];
                sw_d_q[k] <= sw_d[k];
            end
        end
    end

    assign xfer_go  = go_q;
    assign src_pick = src_q;
    assign dst_pick = dst_q;
    assign max_cnt  = max_q;
    assign min_cnt  = min_q;

    AST_ONE_PAIR: assert property (@(posedge clk) disable iff (rst)
        go_q |-> ($countones(src_q) == 1 && $countones(dst_q) == 1))
        else $error("transfer without a single source and destination"); // R3
    AST_QUIET: assert property (@(posedge clk) disable iff (rst)
        !go_q |-> (src_q == '0 && dst_q == '0))
        else $error("pick without a transfer");                          // R3
    AST_PAIR_APART: assert property (@(posedge clk) disable iff (rst)
        (src_q & dst_q) == '0)
        else $error("source and destination coincide");                  // R3
    AST_MASKED_SKIP: assert property (@(posedge clk) disable iff (rst)
        ((src_q | dst_q) & $past(transp)) == '0)
        else $error("transparent node picked");                          // R5
    AST_NO_STRAY: assert property (@(posedge clk) disable iff (rst)
        stray == '0)
        else $error("request steered to a missing child");               // R7
    AST_ROOT_ON_PATH: assert property (@(posedge clk) disable iff (rst)
        go_q |-> (sw_s_q[ROOT] != PORT_IDLE && sw_d_q[ROOT] != PORT_IDLE))
        else $error("root idle during a transfer");                      // R7

endmodule

// File: tb/lsel_tree_bench.sv
module lsel_tree_bench;

    localparam int CW = 4;
    localparam int ROWS = 3;
    localparam int COLS = 4;
    localparam int RR = 1;
    localparam int RC = 1;
    localparam int N = ROWS * COLS;

    typedef struct packed {
        logic [47:0] cnt;
        logic [11:0] msk;
        logic        go;
        logic [3:0]  src;
        logic [3:0]  dst;
        logic [3:0]  mx;
        logic [3:0]  mn;
    } vec_t;

    // counts: node 0 is the rightmost hex digit
    localparam vec_t VECS [9] = '{
        '{48'h555555555555, 12'h000, 1'b0, 4'd0,  4'd0,  4'd5,  4'd5},  // flat, R2
        '{48'h559555555155, 12'h000, 1'b1, 4'd9,  4'd2,  4'd9,  4'd1},  // R1 R3
        '{48'h566666666667, 12'h000, 1'b1, 4'd0,  4'd11, 4'd7,  4'd5},  // gap 2, R2
        '{48'h666666667666, 12'h000, 1'b0, 4'd0,  4'd0,  4'd7,  4'd6},  // gap 1, R2
        '{48'h8c88088f8828, 12'h090, 1'b1, 4'd10, 4'd1,  4'd12, 4'd2},  // masked leaves, R5
        '{48'h77777ef17777, 12'h020, 1'b1, 4'd6,  4'd4,  4'd14, 4'd1},  // masked root, R5
        '{48'h999f99990999, 12'h000, 1'b1, 4'd8,  4'd3,  4'd15, 4'd0},  // full range, R9
        '{48'h123456789abc, 12'hfff, 1'b0, 4'd0,  4'd0,  4'd0,  4'd15}, // all masked, R6
        '{48'h8888d0883888, 12'h040, 1'b1, 4'd7,  4'd3,  4'd13, 4'd3}   // masked relay, R5
    };

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [N*CW-1:0]    job_cnt = '0;
    logic [N-1:0]       transp = '0;
    logic               xfer_go;
    logic [N-1:0]       src_pick;
    logic [N-1:0]       dst_pick;
    logic [N*3-1:0]     sw_src;
    logic [N*3-1:0]     sw_dst;
    logic [CW-1:0]      max_cnt;
    logic [CW-1:0]      min_cnt;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    lsel_tree #(.CW(CW), .ROWS(ROWS), .COLS(COLS), .ROOT_ROW(RR), .ROOT_COL(RC)) u_lsel_tree (
        .clk      (clk),
        .rst      (rst),
        .job_cnt  (job_cnt),
        .transp   (transp),
        .xfer_go  (xfer_go),
        .src_pick (src_pick),
        .dst_pick (dst_pick),
        .sw_src   (sw_src),
        .sw_dst   (sw_dst),
        .max_cnt  (max_cnt),
        .min_cnt  (min_cnt)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // expected switch code at node k for a path from the root to node t (R7)
    function automatic int exp_port(input int k, input int t);
        int kr = k / COLS;
        int kc = k % COLS;
        int tr = t / COLS;
        int tc = t % COLS;
        bit on_col = (kc == RC) && ((kr >= RR && kr <= tr) || (kr <= RR && kr >= tr));
        if (on_col) begin
            if (kr != tr) return (tr < kr) ? 3 : 4;
            return (tc < kc) ? 1 : ((tc > kc) ? 2 : 0);
        end
        if (kr == tr && ((kc > RC && kc <= tc) || (kc < RC && kc >= tc)))
            return (tc < kc) ? 1 : ((tc > kc) ? 2 : 0);
        return 7;
    endfunction

    task automatic run_vec(input logic [47:0] c, input logic [11:0] m, input bit eg,
                           input int es, input int ed, input int emx, input int emn,
                           input string tag);
        logic [N-1:0] e_src;
        logic [N-1:0] e_dst;
        @(negedge clk);
        job_cnt = c;
        transp  = m;
        @(negedge clk);
        e_src = eg ? (N'(1) << es) : '0;
        e_dst = eg ? (N'(1) << ed) : '0;
        chk(xfer_go == eg, {"R2 go ", tag}, xfer_go, eg);
        chk(max_cnt == CW'(emx), {"R1 max ", tag}, max_cnt, emx);
        chk(min_cnt == CW'(emn), {"R1 min ", tag}, min_cnt, emn);
        chk(src_pick == e_src, {"R3 src ", tag}, src_pick, e_src);
        chk(dst_pick == e_dst, {"R3 dst ", tag}, dst_pick, e_dst);
        for (int k = 0; k < N; k++) begin
            int ps = eg ? exp_port(k, es) : 7;
            int pd = eg ? exp_port(k, ed) : 7;
            chk(sw_src[3*k +: 3] == 3'(ps), {"R7 sw_src ", tag}, sw_src[3*k +: 3], ps);
            chk(sw_dst[3*k +: 3] == 3'(pd), {"R7 sw_dst ", tag}, sw_dst[3*k +: 3], pd);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        chk(xfer_go == 1'b0, "R8 reset go", xfer_go, 0);
        chk(src_pick == '0 && dst_pick == '0, "R8 reset picks", {src_pick, dst_pick}, 0);
        chk(max_cnt == '0 && min_cnt == '0, "R8 reset counts", {max_cnt, min_cnt}, 0);
        for (int k = 0; k < N; k++)
            chk(sw_src[3*k +: 3] == 3'd7 && sw_dst[3*k +: 3] == 3'd7, "R8 reset switch",
                {sw_src[3*k +: 3], sw_dst[3*k +: 3]}, 6'o77);
        rst = 1'b0;

        // vector table
        for (int i = 0; i < 9; i++)
            run_vec(VECS[i].cnt, VECS[i].msk, VECS[i].go, int'(VECS[i].src), int'(VECS[i].dst),
                    int'(VECS[i].mx), int'(VECS[i].mn), $sformatf("vec%0d", i));

        // R4: ties, own count beats east child; west beats east; north beats south
        run_vec(48'h555559915555, 12'h000, 1'b1, 5, 4, 9, 1, "tie own");
        run_vec(48'h555559595551, 12'h000, 1'b1, 4, 0, 9, 1, "tie w/e");
        run_vec(48'h159555555595, 12'h000, 1'b1, 1, 11, 9, 1, "tie n/s");

        // R8: output holds the previous result until the next edge
        run_vec(VECS[1].cnt, 12'h000, 1'b1, 9, 2, 9, 1, "hold a");
        @(negedge clk);
        job_cnt = VECS[0].cnt;
        #1;
        chk(xfer_go == 1'b1, "R8 registered hold", xfer_go, 1);
        @(negedge clk);
        chk(xfer_go == 1'b0, "R8 registered update", xfer_go, 0);

        // R8: synchronous reset clears a live transfer
        run_vec(VECS[6].cnt, 12'h000, 1'b1, 8, 3, 15, 0, "pre reset");
        rst = 1'b1;
        @(negedge clk);
        chk(xfer_go == 1'b0 && src_pick == '0, "R8 reset mid-run", {xfer_go, src_pick}, 0);
        chk(sw_src[3*RR*COLS+3*RC +: 3] == 3'd7, "R8 reset root switch",
            sw_src[3*RR*COLS+3*RC +: 3], 7);
        rst = 1'b0;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule